// File: doc/BRIEF.md
# Trap and Interrupt Vectoring Unit

This unit decides when a 32-bit processor must leave its normal instruction flow. The sources are a reset, a hardware exception, a break, a user trap instruction and an external interrupt. When it accepts an event, it sends the fetch logic a new program counter and a flush. It also writes a return address into a fixed general register and updates a small machine-status register. For exceptions it also loads the exception address, exception status, float status and branch-target registers that it holds.

Only one event is accepted per cycle, chosen by a fixed priority. The pipeline sees every redirect one cycle after the request is sampled. The handler's return path may clear the break-in-progress and exception-in-progress bits through two dedicated inputs. Everything else about handlers lies outside this unit.

Top module: `trap_vector_unit`

## Requirements
- R1: In the cycle after `rst` is sampled high, `redirect` is 1 and `redirect_pc` is 0x00000000. `status` equals the parameter `RESET_STATUS` (default 4'b0101). `ear`, `esr`, `fsr` and `btr` are zero, and `rf_we` is 0.
- R2: An accepted user trap redirects to 0x00000008 and writes `cur_pc` into the register indexed by `usr_reg`.
- R3: An accepted interrupt redirects to 0x00000010, writes `cur_pc` into register 14, and clears the interrupt-enable bit (`status[0]`).
- R4: An interrupt is accepted only when `status[0]` (interrupt enable) is 1, `status[1]` (break in progress) is 0 and `status[3]` (exception in progress) is 0. A refused interrupt produces no redirect and leaves `status` unchanged.
- R5: A break, from either `ext_brk` or `sw_brk`, redirects to 0x00000018, writes `cur_pc` into register 16, and sets `status[1]`.
- R6: A hardware exception redirects to 0x00000020, clears `status[2]` (exception enable) and sets `status[3]`. It loads `esr` with {delay-slot bit [12], `exc_cause` [11:7], `exc_detail` [6:0]}, `ear` with `exc_addr`, and `fsr` with `exc_fsr`.
- R7: An exception outside a delay slot writes `cur_pc + 4` into register 17 and leaves `btr` unchanged.
- R8: An exception with `in_dslot` high sets `esr[12]`, loads `btr` with `br_target`, and performs no register write.
- R9: When several events arrive together, only the highest one acts. The order is reset, exception, break, user trap, interrupt.
- R10: `redirect` and `flush` are equal. They are high exactly in the cycle after an event is accepted, and low in a cycle that follows no accepted event.
- R11: `clr_bip` clears `status[1]`. `clr_eip` clears `status[3]` and sets `status[2]`. An event accepted in the same cycle overrides these for the bits it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset event, active high |
| ext_brk | input | 1 | External hardware break request |
| sw_brk | input | 1 | Software break instruction in execute |
| irq | input | 1 | External interrupt request |
| usr_trap | input | 1 | User vector trap instruction in execute |
| usr_reg | input | 5 | Link register chosen by the user trap |
| exc_req | input | 1 | Hardware exception request |
| exc_cause | input | 5 | Exception cause code |
| exc_detail | input | 7 | Cause-specific status |
| exc_addr | input | 32 | Cause-specific address |
| exc_fsr | input | 5 | Float status to record |
| in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| br_target | input | 32 | Target of the branch owning the delay slot |
| cur_pc | input | 32 | PC of the instruction in execute |
| clr_bip | input | 1 | Handler return clears break in progress |
| clr_eip | input | 1 | Handler return clears exception in progress |
| redirect | output | 1 | Load `redirect_pc` into the PC |
| flush | output | 1 | Discard instructions in the pipeline |
| redirect_pc | output | 32 | Vector address |
| rf_we | output | 1 | Link register write enable |
| rf_idx | output | 5 | Link register index |
| rf_data | output | 32 | Link value |
| status | output | 4 | {EIP, EE, BIP, IE} |
| ear | output | 32 | Exception address register |
| esr | output | 13 | Exception status register |
| fsr | output | 5 | Float status register |
| btr | output | 32 | Branch target register |

## Verification
Single directed events show that each source has its own vector, link register and status bits. Stacked requests, such as all sources at once or an exception plus a break, show that the priority is a strict chain rather than a merge. Interrupts are also raised while a break or exception is in progress and while interrupt enable is clear, which tells the acceptance rule apart from a plain priority loss. Delay-slot exceptions and random sequences of mixed events, clears and resets, checked against a bench model, cover the interaction between status clears and new events over long runs.

// File: rtl/trap_vector_unit.sv
module trap_vector_unit #(
  parameter int XLEN = 32,
  parameter int REG_IDX_W = 5,
  parameter int CAUSE_W = 5,
  parameter int DETAIL_W = 7,
  parameter int FSR_W = 5,
  parameter logic [3:0] RESET_STATUS = 4'b0101
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_brk,
  input  logic                  sw_brk,
  input  logic                  irq,
  input  logic                  usr_trap,
  input  logic [REG_IDX_W-1:0]  usr_reg,
  input  logic                  exc_req,
  input  logic [CAUSE_W-1:0]    exc_cause,
  input  logic [DETAIL_W-1:0]   exc_detail,
  input  logic [XLEN-1:0]       exc_addr,
  input  logic [FSR_W-1:0]      exc_fsr,
  input  logic                  in_dslot,
  input  logic [XLEN-1:0]       br_target,
  input  logic [XLEN-1:0]       cur_pc,
  input  logic                  clr_bip,
  input  logic                  clr_eip,
  output logic                  redirect,
  output logic                  flush,
  output logic [XLEN-1:0]       redirect_pc,
  output logic                  rf_we,
  output logic [REG_IDX_W-1:0]  rf_idx,
  output logic [XLEN-1:0]       rf_data,
  output logic [3:0]            status,
  output logic [XLEN-1:0]       ear,
  output logic [CAUSE_W+DETAIL_W:0] esr,
  output logic [FSR_W-1:0]      fsr,
  output logic [XLEN-1:0]       btr
);
  localparam int ESR_W = CAUSE_W + DETAIL_W + 1;
  localparam logic [XLEN-1:0] VEC_USR = XLEN'(32'h08);
  localparam logic [XLEN-1:0] VEC_IRQ = XLEN'(32'h10);
  localparam logic [XLEN-1:0] VEC_BRK = XLEN'(32'h18);
  localparam logic [XLEN-1:0] VEC_EXC = XLEN'(32'h20);
  localparam int IE = 0, BIP = 1, EE = 2, EIP = 3;

  wire brk_any  = ext_brk | sw_brk;
  wire take_exc = exc_req;
  wire take_brk = !exc_req && brk_any;
  wire take_usr = !exc_req && !brk_any && usr_trap;
  wire irq_ok   = status[IE] && !status[BIP] && !status[EIP];
  wire take_irq = !exc_req && !brk_any && !usr_trap && irq && irq_ok;
  wire take_any = take_exc | take_brk | take_usr | take_irq;

  logic [3:0]           n_status;
  logic [XLEN-1:0]      n_pc, n_data, n_ear, n_btr;
  logic                 n_we;
  logic [REG_IDX_W-1:0] n_idx;
  logic [ESR_W-1:0]     n_esr;
  logic [FSR_W-1:0]     n_fsr;

  always_comb begin
    n_status = status;
    if (clr_bip) n_status[BIP] = 1'b0;
    if (clr_eip) begin
      n_status[EIP] = 1'b0;
      n_status[EE]  = 1'b1;
    end
    n_pc = '0; n_we = 1'b0; n_idx = '0; n_data = '0;
    n_ear = ear; n_esr = esr; n_fsr = fsr; n_btr = btr;
    if (take_exc) begin
      n_pc = VEC_EXC;
      n_status[EE]  = 1'b0;
      n_status[EIP] = 1'b1;
      n_esr = {in_dslot, exc_cause, exc_detail};
      n_ear = exc_addr;
      n_fsr = exc_fsr;
      if (in_dslot) n_btr = br_target;
      else begin
        n_we = 1'b1; n_idx = REG_IDX_W'(17); n_data = cur_pc + XLEN'(4);
      end
    end else if (take_brk) begin
      n_pc = VEC_BRK; n_status[BIP] = 1'b1;
      n_we = 1'b1; n_idx = REG_IDX_W'(16); n_data = cur_pc;
    end else if (take_usr) begin
      n_pc = VEC_USR;
      n_we = 1'b1; n_idx = usr_reg; n_data = cur_pc;
    end else if (take_irq) begin
      n_pc = VEC_IRQ; n_status[IE] = 1'b0;
      n_we = 1'b1; n_idx = REG_IDX_W'(14); n_data = cur_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect <= 1'b1; redirect_pc <= '0;
      rf_we <= 1'b0; rf_idx <= '0; rf_data <= '0;
      status <= RESET_STATUS;
      ear <= '0; esr <= '0; fsr <= '0; btr <= '0;
    end else begin
      redirect <= take_any; redirect_pc <= n_pc;
      rf_we <= n_we; rf_idx <= n_idx; rf_data <= n_data;
      status <= n_status;
      ear <= n_ear; esr <= n_esr; fsr <= n_fsr; btr <= n_btr;
    end
  end

  assign flush = redirect;

  assert_reset_vector_R1: assert property (@(posedge clk)
    $past(rst) |-> (redirect && redirect_pc == '0 && status == RESET_STATUS && !rf_we));

  assert_irq_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !exc_req && !brk_any && !usr_trap && (!status[IE] || status[BIP] || status[EIP]))
      |=> !redirect);

  assert_exc_first_R9: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (redirect && redirect_pc == VEC_EXC && status[EIP] && !status[EE]));

  assert_brk_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (brk_any && !exc_req) |=> (redirect_pc == VEC_BRK && status[BIP] && rf_idx == REG_IDX_W'(16)));

  assert_dslot_no_link_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_req && in_dslot) |=> (!rf_we && btr == $past(br_target) && esr[ESR_W-1]));

  assert_quiet_no_redirect_R10: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !brk_any && !usr_trap && !irq) |=> !redirect);
endmodule

// File: tb/test_trap_vector_unit.sv
`timescale 1ns/1ps
module test_trap_vector_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_brk = 0, sw_brk = 0, irq = 0, usr_trap = 0, exc_req = 0, in_dslot = 0;
  logic clr_bip = 0, clr_eip = 0;
  logic [4:0] usr_reg = '0, exc_cause = '0, exc_fsr = '0;
  logic [6:0] exc_detail = '0;
  logic [31:0] exc_addr = '0, br_target = '0, cur_pc = '0;
  logic redirect, flush, rf_we;
  logic [31:0] redirect_pc, rf_data, ear, btr;
  logic [4:0] rf_idx, fsr;
  logic [3:0] status;
  logic [12:0] esr;

  int checks = 0, fails = 0;
  logic [3:0] m_st; logic [31:0] m_ear, m_btr; logic [12:0] m_esr; logic [4:0] m_fsr;
  logic e_red, e_we; logic [31:0] e_pc, e_data; logic [4:0] e_idx;

  always #2.5 clk = ~clk;

  trap_vector_unit i_trap_vector_unit (
    .clk(clk), .rst(rst), .ext_brk(ext_brk), .sw_brk(sw_brk), .irq(irq),
    .usr_trap(usr_trap), .usr_reg(usr_reg), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_detail(exc_detail), .exc_addr(exc_addr), .exc_fsr(exc_fsr), .in_dslot(in_dslot),
    .br_target(br_target), .cur_pc(cur_pc), .clr_bip(clr_bip), .clr_eip(clr_eip),
    .redirect(redirect), .flush(flush), .redirect_pc(redirect_pc), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_data(rf_data), .status(status), .ear(ear), .esr(esr),
    .fsr(fsr), .btr(btr));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (rst) return "R1";
    if (exc_req) return in_dslot ? "R8" : "R7";
    if (ext_brk || sw_brk) return "R5";
    if (usr_trap) return "R2";
    if (irq) return "R4";
    return "R10";
  endfunction

  task automatic model();
    logic ok;
    e_red = 0; e_we = 0; e_pc = '0; e_idx = '0; e_data = '0;
    if (rst) begin
      e_red = 1; m_st = 4'b0101; m_ear = '0; m_esr = '0; m_fsr = '0; m_btr = '0;
      return;
    end
    ok = m_st[0] && !m_st[1] && !m_st[3];
    if (clr_bip) m_st[1] = 0;
    if (clr_eip) begin m_st[3] = 0; m_st[2] = 1; end
    if (exc_req) begin
      e_red = 1; e_pc = 32'h20; m_st[2] = 0; m_st[3] = 1;
      m_esr = {in_dslot, exc_cause, exc_detail}; m_ear = exc_addr; m_fsr = exc_fsr;
      if (in_dslot) m_btr = br_target;
      else begin e_we = 1; e_idx = 17; e_data = cur_pc + 4; end
    end else if (ext_brk || sw_brk) begin
      e_red = 1; e_pc = 32'h18; m_st[1] = 1; e_we = 1; e_idx = 16; e_data = cur_pc;
    end else if (usr_trap) begin
      e_red = 1; e_pc = 32'h08; e_we = 1; e_idx = usr_reg; e_data = cur_pc;
    end else if (irq && ok) begin
      e_red = 1; e_pc = 32'h10; m_st[0] = 0; e_we = 1; e_idx = 14; e_data = cur_pc;
    end
  endtask

  task automatic step();
    string t;
    t = tag_of();
    model();
    @(posedge clk); @(negedge clk);
    chk("R10", "redirect", 32'(redirect), 32'(e_red));
    chk("R10", "flush", 32'(flush), 32'(e_red));
    chk(t, "redirect_pc", redirect_pc, e_pc);
    chk(t, "rf_we", 32'(rf_we), 32'(e_we));
    if (e_we) begin
      chk(t, "rf_idx", 32'(rf_idx), 32'(e_idx));
      chk(t, "rf_data", rf_data, e_data);
    end
    chk("R11", "status", 32'(status), 32'(m_st));
    chk("R6", "ear", ear, m_ear);
    chk("R6", "esr", 32'(esr), 32'(m_esr));
    chk("R6", "fsr", 32'(fsr), 32'(m_fsr));
    chk("R8", "btr", btr, m_btr);
  endtask

  task automatic idle();
    rst = 0; ext_brk = 0; sw_brk = 0; irq = 0; usr_trap = 0; exc_req = 0;
    in_dslot = 0; clr_bip = 0; clr_eip = 0;
    cur_pc = $urandom; usr_reg = 5'($urandom); exc_cause = 5'($urandom);
    exc_detail = 7'($urandom); exc_addr = $urandom; exc_fsr = 5'($urandom);
    br_target = $urandom;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    @(negedge clk);
    idle(); rst = 1; step();              // R1 reset state
    idle(); usr_trap = 1; step();         // R2
    idle(); irq = 1; step();              // R3 interrupt taken, IE cleared
    idle(); irq = 1; step();              // R4 refused: IE clear
    idle(); rst = 1; step();
    idle(); sw_brk = 1; step();           // R5 software break
    idle(); irq = 1; step();              // R4 refused: BIP set
    idle(); clr_bip = 1; step();          // R11
    idle(); ext_brk = 1; step();          // R5 external break
    idle(); clr_bip = 1; exc_req = 1; step(); // R7 exception + clear together
    idle(); irq = 1; step();              // R4 refused: EIP set
    idle(); clr_eip = 1; step();          // R11 EE restored
    idle(); exc_req = 1; in_dslot = 1; step(); // R8 delay slot
    idle(); rst = 1; step();
    idle(); exc_req = 1; ext_brk = 1; sw_brk = 1; usr_trap = 1; irq = 1; step(); // R9
    idle(); clr_eip = 1; step();
    idle(); usr_trap = 1; irq = 1; step(); // R9 user trap over interrupt
    idle(); step();                        // R10 quiet cycle
    for (int i = 0; i < 4000; i++) begin
      idle();
      rst      = ($urandom % 60) == 0;
      exc_req  = ($urandom % 9) == 0;
      in_dslot = ($urandom % 2) == 0;
      ext_brk  = ($urandom % 10) == 0;
      sw_brk   = ($urandom % 10) == 0;
      usr_trap = ($urandom % 7) == 0;
      irq      = ($urandom % 3) == 0;
      clr_bip  = ($urandom % 4) == 0;
      clr_eip  = ($urandom % 4) == 0;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule